// File: doc/BRIEF.md
# Trigger-Latency Ring Buffer with Derandomizer

This block keeps a short history of wide detector data so that a first-level trigger decision, which arrives a fixed number of crossings late, can still pick out the data it refers to. Every clock (one bunch crossing) the block writes the incoming 240-bit line into a 164-entry circular memory. The write pointer never stops and never checks whether a slot is still wanted, so each line lives for exactly 164 crossings before new data replaces it.

A trigger accept carries a latency and a group length. The block records the ring address that lies `latency` crossings behind the write pointer. A copy engine then reads up to three consecutive lines from that address through the second memory port and writes them into a 16-line derandomizing FIFO, while new lines keep arriving through the write port. Triggers that arrive while a copy runs wait in a small pending queue. A downstream reader drains the derandomizer at its own pace through a first-word-fall-through read port. When a whole group cannot fit, that group is discarded and a sticky overflow flag is raised.

Top module: `trd_trigger_buffer`

## Requirements
- R1: After reset, `empty` is 1 and `overflow` is 0. A later reset returns `overflow` to 0.
- R2: After reset, one line is written per clock at a pointer that steps 0, 1, …, 163 and then wraps to 0. A line is replaced exactly 164 crossings after it was written. A trigger with latency up to 150 still returns the original line.
- R3: A trigger sampled in the same cycle as the write of line number k, with latency L (3 to 150), selects line number k−L as the first line of its group.
- R4: A group holds `grp_len` lines (1, 2 or 3; the value 0 is treated as 1). The lines come from consecutive ring addresses, wrapping past 163, and enter the derandomizer oldest first.
- R5: Triggers that arrive on consecutive cycles, or while a copy is running, are queued and not dropped. Their groups come out whole and in trigger order.
- R6: The derandomizer is first-word-fall-through. While `empty` is 0, `rd_data` shows the oldest stored line and holds its value until `rd_en` removes it. `rd_en` while `empty` is 1 has no effect.
- R7: If the derandomizer cannot take every line of a group (occupancy plus group length above 16), none of that group's lines are stored and `overflow` becomes 1. A later group that fits is still stored.
- R8: Once set, `overflow` stays 1 until reset, including after the derandomizer is drained.
- R9: A line entering the derandomizer in the same cycle as a read removes one does not disturb the stored data or its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 240 | Data line written into the ring this crossing |
| trig_acc | input | 1 | Trigger accept pulse, one cycle per trigger |
| trig_latency | input | 8 | Crossings between the selected line and the trigger |
| grp_len | input | 2 | Lines to copy for this trigger (0 acts as 1) |
| rd_en | input | 1 | Remove the head line from the derandomizer |
| rd_data | output | 240 | Head line of the derandomizer |
| empty | output | 1 | Derandomizer holds no line |
| overflow | output | 1 | Sticky: a group was discarded |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a trigger accept lands while the copy engine is busy moving an earlier group. In the second, the engine pushes a copied line into the derandomizer in the same cycle the reader pops the head. The first is provoked by triggers on back-to-back cycles with different latencies and lengths. The second is provoked by triggers spaced three cycles apart while the reader removes a line on every cycle the derandomizer is not empty. In both cases every line is judged against a line value computed from the crossing count at which the trigger was sampled. Any lost, duplicated or reordered line therefore shows as a mismatch, and `overflow` must stay 0 throughout.

// File: rtl/trd_pkg.sv
package trd_pkg;
    localparam int RING_DEPTH = 164;
    localparam int RING_AW    = $clog2(RING_DEPTH);
    localparam int GRP_W      = 2;

    typedef logic [RING_AW-1:0] ring_addr_t;
    typedef logic [GRP_W-1:0]   grp_t;

    // one queued trigger: first ring address and number of lines
    typedef struct packed {
        ring_addr_t start;
        grp_t       len;
    } trig_req_t;

    typedef enum logic {CP_IDLE, CP_COPY} copy_state_e;

    function automatic ring_addr_t ring_next(ring_addr_t a);
        return (a == ring_addr_t'(RING_DEPTH - 1)) ? '0 : a + 1'b1;
    endfunction

    function automatic ring_addr_t ring_back(ring_addr_t wp, ring_addr_t lag);
        int s;
        s = int'(wp) - int'(lag);
        if (s < 0) s = s + RING_DEPTH;
        return ring_addr_t'(s);
    endfunction

    function automatic grp_t grp_clamp(grp_t g);
        return (g == '0) ? grp_t'(1) : g;
    endfunction
endpackage

// File: rtl/trd_ring_mem.sv
module trd_ring_mem
    import trd_pkg::*;
#(
    parameter int W = 240
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     wr_line,
    input  logic             re,
    input  ring_addr_t       raddr,
    output logic [W-1:0]     rd_line,
    output ring_addr_t       wp
);
    logic [W-1:0] mem [RING_DEPTH];

    // write side: unconditional, one line per crossing
    always_ff @(posedge clk) begin
        if (!rst) mem[wp] <= wr_line;
    end

    always_ff @(posedge clk) begin
        if (rst) wp <= '0;
        else     wp <= ring_next(wp);
    end

    // read side: independent port, registered output
    always_ff @(posedge clk) begin
        if (re) rd_line <= mem[raddr];
    end
endmodule

// File: rtl/trd_fifo.sv
module trd_fifo #(
    parameter int W = 8,
    parameter int D = 4,
    localparam int PW = (D > 1) ? $clog2(D) : 1,
    localparam int CW = $clog2(D + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [D];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] adv(logic [PW-1:0] p);
        return (p == PW'(D - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(D));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= adv(wptr);
            if (do_pop)  rptr <= adv(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/trd_copy_ctrl.sv
module trd_copy_ctrl
    import trd_pkg::*;
#(
    parameter int DR_DEPTH = 16,
    localparam int DR_CW = $clog2(DR_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pend_empty,
    input  trig_req_t        pend_head,
    output logic             pend_pop,
    input  logic [DR_CW-1:0] dr_count,
    output logic             mem_re,
    output ring_addr_t       mem_raddr,
    output logic             line_valid,
    output logic             drop
);
    copy_state_e st;
    ring_addr_t  cur;
    grp_t        left;
    grp_t        hlen;
    logic        rd_q;
    logic        fits;

    assign hlen = grp_clamp(pend_head.len);
    // space check counts the line still in flight from the ring read port
    assign fits = (int'(dr_count) + int'(rd_q) + int'(hlen)) <= DR_DEPTH;

    assign pend_pop   = (st == CP_IDLE) && !pend_empty;
    assign drop       = pend_pop && !fits;
    assign mem_re     = (st == CP_COPY);
    assign mem_raddr  = cur;
    assign line_valid = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= CP_IDLE;
            cur  <= '0;
            left <= '0;
            rd_q <= 1'b0;
        end else begin
            rd_q <= mem_re;
            case (st)
                CP_IDLE: begin
                    if (pend_pop && fits) begin
                        st   <= CP_COPY;
                        cur  <= pend_head.start;
                        left <= hlen;
                    end
                end
                CP_COPY: begin
                    cur  <= ring_next(cur);
                    left <= left - 1'b1;
                    if (left == grp_t'(1)) st <= CP_IDLE;
                end
                default: st <= CP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/trd_trigger_buffer.sv
module trd_trigger_buffer
    import trd_pkg::*;
#(
    parameter int LINE_W     = 240,
    parameter int DR_DEPTH   = 16,
    parameter int PEND_DEPTH = 4,
    localparam int DR_CW   = $clog2(DR_DEPTH + 1),
    localparam int PEND_CW = $clog2(PEND_DEPTH + 1),
    localparam int REQ_W   = $bits(trig_req_t)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LINE_W-1:0]  line_in,
    input  logic               trig_acc,
    input  logic [RING_AW-1:0] trig_latency,
    input  logic [GRP_W-1:0]   grp_len,
    input  logic               rd_en,
    output logic [LINE_W-1:0]  rd_data,
    output logic               empty,
    output logic               overflow
);
    ring_addr_t         wp;
    ring_addr_t         mem_raddr;
    logic               mem_re;
    logic [LINE_W-1:0]  ring_line;

    trig_req_t          new_req;
    trig_req_t          pend_head;
    logic               pend_pop, pend_empty, pend_full;
    logic [PEND_CW-1:0] pend_count;

    logic               dr_push, dr_full;
    logic [DR_CW-1:0]   dr_count;
    logic               drop;

    trd_ring_mem #(.W(LINE_W)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_line (line_in),
        .re      (mem_re),
        .raddr   (mem_raddr),
        .rd_line (ring_line),
        .wp      (wp)
    );

    always_comb begin
        new_req.start = ring_back(wp, trig_latency);
        new_req.len   = grp_clamp(grp_len);
    end

    trd_fifo #(.W(REQ_W), .D(PEND_DEPTH)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .push  (trig_acc),
        .din   (new_req),
        .pop   (pend_pop),
        .dout  (pend_head),
        .count (pend_count),
        .empty (pend_empty),
        .full  (pend_full)
    );

    trd_copy_ctrl #(.DR_DEPTH(DR_DEPTH)) u_copy (
        .clk        (clk),
        .rst        (rst),
        .pend_empty (pend_empty),
        .pend_head  (pend_head),
        .pend_pop   (pend_pop),
        .dr_count   (dr_count),
        .mem_re     (mem_re),
        .mem_raddr  (mem_raddr),
        .line_valid (dr_push),
        .drop       (drop)
    );

    trd_fifo #(.W(LINE_W), .D(DR_DEPTH)) u_derand (
        .clk   (clk),
        .rst   (rst),
        .push  (dr_push),
        .din   (ring_line),
        .pop   (rd_en),
        .dout  (rd_data),
        .count (dr_count),
        .empty (empty),
        .full  (dr_full)
    );

    // sticky loss flag: discarded group or trigger refused by a full queue
    always_ff @(posedge clk) begin
        if (rst)                              overflow <= 1'b0;
        else if (drop || (trig_acc && pend_full)) overflow <= 1'b1;
    end
endmodule

// File: rtl/trd_trigger_buffer_chk.sv
module trd_trigger_buffer_chk
    import trd_pkg::*;
#(
    parameter int LINE_W  = 240,
    parameter int PEND_CW = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               empty,
    input logic               overflow,
    input logic               rd_en,
    input logic [LINE_W-1:0]  rd_data,
    input ring_addr_t         wp,
    input logic               dr_push,
    input logic               dr_full,
    input logic               pend_pop,
    input logic               pend_empty,
    input logic               pend_full,
    input logic [PEND_CW-1:0] pend_count,
    input logic               trig_acc
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (empty && !overflow));

    // R2
    ring_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (wp == ring_next($past(wp))));

    // R5
    pend_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_acc && !pend_full) |=> (!pend_empty && pend_count != '0));

    // R5
    pend_pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pend_pop |-> !pend_empty);

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty && !rd_en) |=> $stable(rd_data));

    // R7
    no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
        !(dr_push && dr_full));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind trd_trigger_buffer trd_trigger_buffer_chk #(
    .LINE_W  (LINE_W),
    .PEND_CW (PEND_CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .empty      (empty),
    .overflow   (overflow),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .wp         (wp),
    .dr_push    (dr_push),
    .dr_full    (dr_full),
    .pend_pop   (pend_pop),
    .pend_empty (pend_empty),
    .pend_full  (pend_full),
    .pend_count (pend_count),
    .trig_acc   (trig_acc)
);

// File: tb/test_trd_trigger_buffer.sv
module test_trd_trigger_buffer;
    import trd_pkg::*;

    localparam int LINE_W = 240;

    logic               clk;
    logic               rst;
    logic [LINE_W-1:0]  line_in;
    logic               trig_acc;
    logic [RING_AW-1:0] trig_latency;
    logic [GRP_W-1:0]   grp_len;
    logic               rd_en;
    logic [LINE_W-1:0]  rd_data;
    logic               empty;
    logic               overflow;

    int unsigned        xing;
    int                 n_cmp;
    int                 n_bad;
    logic [LINE_W-1:0]  exp_q [$];

    trd_trigger_buffer i_trd_trigger_buffer (
        .clk          (clk),
        .rst          (rst),
        .line_in      (line_in),
        .trig_acc     (trig_acc),
        .trig_latency (trig_latency),
        .grp_len      (grp_len),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .empty        (empty),
        .overflow     (overflow)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [LINE_W-1:0] mkline(int unsigned k);
        logic [255:0] t;
        t = {8{k ^ 32'h5A00_0000}};
        return t[LINE_W-1:0];
    endfunction

    // crossing index of the write at the next rising edge
    always @(posedge clk) begin
        if (rst) xing <= 0;
        else     xing <= xing + 1;
    end

    always @(negedge clk) line_in = mkline(xing);

    task automatic check_line(input string req, input logic [LINE_W-1:0] act,
                              input logic [LINE_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; returns at the following negedge
    task automatic fire(input int lag, input int len, input bit keep);
        int n;
        n = (len == 0) ? 1 : len;
        trig_acc     = 1'b1;
        trig_latency = RING_AW'(lag);
        grp_len      = GRP_W'(len);
        if (keep)
            for (int i = 0; i < n; i++)
                exp_q.push_back(mkline(xing - lag + i));
        @(negedge clk);
        trig_acc = 1'b0;
    endtask

    task automatic drain(input int n, input string req);
        int got;
        int wait_n;
        got = 0;
        wait_n = 0;
        while (got < n && wait_n < 400) begin
            @(negedge clk);
            if (!empty) begin
                if (exp_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL %s: actual extra line %h expected none", req, rd_data);
                end else begin
                    check_line(req, rd_data, exp_q.pop_front());
                end
                rd_en = 1'b1;
                got++;
                wait_n = 0;
            end else begin
                rd_en = 1'b0;
                wait_n++;
            end
        end
        @(negedge clk);
        rd_en = 1'b0;
        if (got < n) begin
            n_cmp++;
            n_bad++;
            $display("FAIL %s: actual %0d lines expected %0d", req, got, n);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check_bit("R1 empty after reset", empty, 1'b1);
        check_bit("R1 overflow after reset", overflow, 1'b0);
    endtask

    task automatic t_single();
        idle(200);
        fire(10, 1, 1'b1);
        drain(1, "R3 single line lat 10");
        check_bit("R6 empty after drain", empty, 1'b1);
    endtask

    task automatic t_groups();
        fire(40, 3, 1'b1);
        drain(3, "R4 group of 3");
        fire(3, 2, 1'b1);
        drain(2, "R3 shortest latency");
        fire(150, 3, 1'b1);
        drain(3, "R2 long latency survives");
        fire(25, 0, 1'b1);
        drain(1, "R4 zero length acts as one");
        check_bit("R4 no extra line", empty, 1'b1);
    endtask

    task automatic t_burst();
        fire(12, 3, 1'b1);
        fire(30, 2, 1'b1);
        fire(50, 3, 1'b1);
        drain(8, "R5 back-to-back triggers");
        check_bit("R5 nothing lost", overflow, 1'b0);
        check_bit("R5 empty after burst", empty, 1'b1);
    endtask

    task automatic t_empty_read();
        rd_en = 1'b1;
        idle(3);
        rd_en = 1'b0;
        check_bit("R6 empty read ignored", empty, 1'b1);
        fire(20, 2, 1'b1);
        idle(10);
        drain(2, "R6 head held then popped");
        check_bit("R6 empty after pair", empty, 1'b1);
    endtask

    task automatic t_concurrent();
        fork
            begin
                for (int i = 0; i < 6; i++) begin
                    fire(15 + 7 * i, 3, 1'b1);
                    idle(2);
                end
            end
            drain(18, "R9 push and pop together");
        join
        check_bit("R9 empty after stream", empty, 1'b1);
        check_bit("R9 no loss", overflow, 1'b0);
    endtask

    task automatic t_overflow();
        do_reset();
        idle(30);
        for (int i = 0; i < 5; i++) begin
            fire(20, 3, 1'b1);
            idle(8);
        end
        check_bit("R7 fifteen lines fit", overflow, 1'b0);
        fire(20, 3, 1'b0);
        idle(8);
        check_bit("R7 oversize group flagged", overflow, 1'b1);
        fire(20, 1, 1'b1);
        idle(8);
        drain(16, "R7 dropped group absent");
        check_bit("R7 drained", empty, 1'b1);
        check_bit("R8 flag kept after drain", overflow, 1'b1);
        idle(5);
        check_bit("R8 flag still kept", overflow, 1'b1);
        do_reset();
        check_bit("R1 reset clears flag", overflow, 1'b0);
        check_bit("R1 reset empties", empty, 1'b1);
    endtask

    initial begin
        n_cmp        = 0;
        n_bad        = 0;
        rst          = 1'b1;
        trig_acc     = 1'b0;
        trig_latency = '0;
        grp_len      = '0;
        rd_en        = 1'b0;
        t_reset();
        t_single();
        t_groups();
        t_burst();
        t_empty_read();
        t_concurrent();
        t_overflow();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule